// File: doc/BRIEF.md
# PLL Divider Search Engine

This block picks the integer pre-divider and feedback divider settings for a clock synthesizer. It takes a reference frequency and a requested output rate, both given as whole numbers in hertz. It then steps through every legal pre-divider value, one candidate at a time. For each value it derives the feedback divider and the frequency that setting would actually produce. The candidate whose frequency lands closest to the internal target is kept. The internal target is twice the requested rate.

A search starts with a one-cycle `start` pulse. All arithmetic goes through one shared sequential divider that produces one quotient bit per clock, so a search takes a few thousand cycles at most. When the search ends, the block updates its outputs and pulses `done` for one cycle. The outputs are the chosen pre-divider, the chosen feedback divider, both packed into the two control bytes the analog side expects, the achieved rate and a `valid` flag. The usual reference is 24 MHz.

Top module: `pll_div_search`

## Requirements
- R1: The internal target is 2 × `req_hz`. When a candidate is accepted, `rate_hz` equals half of the best candidate frequency, rounded down.
- R2: Pre-divider p runs from ceil(`fin_hz` / 40 MHz) up to min(floor(`fin_hz` / 5 MHz), 31), inclusive, in ascending order. Values outside that range are never chosen.
- R3: For each p, the feedback divider is floor(target × p / `fin_hz`). The candidate is rejected if that value is below 12, equal to 15, or above 511.
- R4: An accepted candidate's frequency is floor(fbdiv × `fin_hz` / p), and its error is the absolute difference from the target. The best candidate is replaced only on a strictly smaller error, so among equal errors the smallest p wins.
- R5: If no candidate is accepted, `rate_hz` becomes 0 and `valid` becomes 0, while `prediv` and `fbdiv` keep their previous values.
- R6: `ctrl0` carries fbdiv bit 8 in bit 5 and the pre-divider in bits 4..0, with bits 7..6 at zero. `ctrl1` carries fbdiv bits 7..0.
- R7: Each search ends with `done` high for exactly one cycle. `prediv`, `fbdiv`, `rate_hz` and `valid` change only in the cycle where `done` is high.
- R8: A `start` pulse that arrives while a search is running is ignored and does not alter that search's result.
- R9: After reset, `prediv`, `fbdiv`, `ctrl0`, `ctrl1`, `rate_hz`, `valid` and `done` are all zero.
- R10: A reference of 0 Hz gives an empty range, and the search finishes with the outcome of R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins a search when idle |
| fin_hz | input | 32 | Reference frequency in Hz, captured at start |
| req_hz | input | 32 | Requested output rate in Hz, captured at start |
| prediv | output | 5 | Chosen pre-divider |
| fbdiv | output | 9 | Chosen feedback divider |
| ctrl0 | output | 8 | Packed control byte: fbdiv bit 8 and the pre-divider |
| ctrl1 | output | 8 | Packed control byte: fbdiv bits 7..0 |
| rate_hz | output | 32 | Achieved rate in Hz, or 0 when nothing was accepted |
| valid | output | 1 | The last search accepted a candidate |
| done | output | 1 | One-cycle pulse at the end of a search |

## Verification
Any fault in the best-candidate bookkeeping, such as a non-strict compare, a skipped bound or a missed exclusion, shows up in the same `done` cycle as a wrong divider pair or rate. The vectors are built so that each of these mistakes picks a different p. A state machine that loses its place never raises `done` at all, and a divider that is off by one bit changes the feedback divider in the first search. Stale dividers after an empty search show up only when that search follows a successful one, which is why the empty cases come after known results.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

    // Search sequencer states
    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_LO     = 3'd1,   // lower pre-divider bound division
        S_HI     = 3'd2,   // upper pre-divider bound division
        S_FB     = 3'd3,   // feedback divider division for current p
        S_FQ     = 3'd4,   // candidate frequency division
        S_FINISH = 3'd5
    } srch_state_t;

endpackage

// File: rtl/pll_seq_div.sv
module pll_seq_div #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic [W-1:0]  quo;
        logic [W-1:0]  rem;
        logic [W-1:0]  den;
    } div_regs_t;

    div_regs_t q, d;
    logic [W:0] rem_sh;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        rem_sh = {q.rem, q.quo[W-1]};
        if (!q.busy) begin
            if (start) begin
                d.busy = 1'b1;
                d.cnt  = CW'(W);
                d.quo  = dividend;
                d.rem  = '0;
                d.den  = divisor;
            end
        end else begin
            if (rem_sh >= {1'b0, q.den}) begin
                d.rem = W'(rem_sh - {1'b0, q.den});
                d.quo = {q.quo[W-2:0], 1'b1};
            end else begin
                d.rem = rem_sh[W-1:0];
                d.quo = {q.quo[W-2:0], 1'b0};
            end
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CW'(1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy     = q.busy;
    assign done     = q.done;
    assign quotient = q.quo;

    // R3: every quotient is delivered by a single done pulse
    a_r3_div_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);
    // R3: the sequencer never restarts a division in flight
    a_r3_div_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !q.busy);

endmodule

// File: rtl/pll_cand_judge.sv
module pll_cand_judge #(
    parameter int PW     = 64,
    parameter int TW     = 33,
    parameter int ERR_W  = 32,
    parameter int FB_MIN = 12,
    parameter int FB_BAN = 15,
    parameter int FB_MAX = 511
) (
    input  logic [PW-1:0]    fb_raw,
    input  logic [PW-1:0]    cand_hz,
    input  logic [TW-1:0]    target_hz,
    input  logic [ERR_W-1:0] best_err,
    output logic             fb_ok,
    output logic [ERR_W-1:0] err,
    output logic             better
);
    logic [PW-1:0] tgt_ext;

    always_comb begin
        tgt_ext = PW'(target_hz);
        fb_ok   = (fb_raw >= PW'(FB_MIN)) && (fb_raw != PW'(FB_BAN))
               && (fb_raw <= PW'(FB_MAX));
        if (tgt_ext >= cand_hz) err = ERR_W'(tgt_ext - cand_hz);
        else                    err = ERR_W'(cand_hz - tgt_ext);
        better  = err < best_err;
    end

endmodule

// File: rtl/pll_field_pack.sv
module pll_field_pack #(
    parameter int PRE_W  = 5,
    parameter int FB_W   = 9,
    parameter int CTRL_W = 8
) (
    input  logic [PRE_W-1:0]  prediv,
    input  logic [FB_W-1:0]   fbdiv,
    output logic [CTRL_W-1:0] ctrl0,
    output logic [CTRL_W-1:0] ctrl1
);
    assign ctrl0 = CTRL_W'({fbdiv[FB_W-1], prediv});
    assign ctrl1 = fbdiv[CTRL_W-1:0];
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
    import pll_search_pkg::*;
#(
    parameter int FW         = 32,
    parameter int PRE_W      = 5,
    parameter int FB_W       = 9,
    parameter int CTRL_W     = 8,
    parameter int PW         = 64,
    parameter int ERR_W      = 32,
    parameter int FB_MIN     = 12,
    parameter int FB_BAN     = 15,
    parameter int PFD_MAX_HZ = 40_000_000,
    parameter int PFD_MIN_HZ = 5_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FW-1:0]     fin_hz,
    input  logic [FW-1:0]     req_hz,
    output logic [PRE_W-1:0]  prediv,
    output logic [FB_W-1:0]   fbdiv,
    output logic [CTRL_W-1:0] ctrl0,
    output logic [CTRL_W-1:0] ctrl1,
    output logic [FW-1:0]     rate_hz,
    output logic              valid,
    output logic              done
);
    localparam int            TW     = FW + 1;
    localparam int            FB_MAX = (1 << FB_W) - 1;
    localparam logic [FW-1:0] P_CAP  = FW'((1 << PRE_W) - 1);

    typedef struct packed {
        srch_state_t       state;
        logic [FW-1:0]     fin;
        logic [TW-1:0]     tgt;
        logic [FW-1:0]     p;
        logic [FW-1:0]     p_lo;
        logic [FW-1:0]     p_hi;
        logic [FB_W-1:0]   fb;
        logic [PRE_W-1:0]  best_p;
        logic [FB_W-1:0]   best_fb;
        logic [ERR_W-1:0]  best_err;
        logic [TW-1:0]     best_freq;
        logic              found;
        logic [PRE_W-1:0]  prediv;
        logic [FB_W-1:0]   fbdiv;
        logic [FW-1:0]     rate;
        logic              valid;
        logic              done;
        logic              div_start;
        logic [PW-1:0]     div_a;
        logic [PW-1:0]     div_b;
    } srch_regs_t;

    srch_regs_t q, d;

    logic          div_busy, div_done;
    logic [PW-1:0] div_q;
    logic          fb_ok, better;
    logic [ERR_W-1:0] cand_err;

    pll_seq_div #(.W(PW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (q.div_start),
        .dividend (q.div_a),
        .divisor  (q.div_b),
        .busy     (div_busy),
        .done     (div_done),
        .quotient (div_q)
    );

    pll_cand_judge #(
        .PW(PW), .TW(TW), .ERR_W(ERR_W),
        .FB_MIN(FB_MIN), .FB_BAN(FB_BAN), .FB_MAX(FB_MAX)
    ) u_judge (
        .fb_raw    (div_q),
        .cand_hz   (div_q),
        .target_hz (q.tgt),
        .best_err  (q.best_err),
        .fb_ok     (fb_ok),
        .err       (cand_err),
        .better    (better)
    );

    pll_field_pack #(.PRE_W(PRE_W), .FB_W(FB_W), .CTRL_W(CTRL_W)) u_pack (
        .prediv (q.prediv),
        .fbdiv  (q.fbdiv),
        .ctrl0  (ctrl0),
        .ctrl1  (ctrl1)
    );

    // Sequencer scratch values
    logic          launch;
    logic          advance;
    logic [PW-1:0] la, lb;
    logic [FW-1:0] p_next;
    logic [FW-1:0] hi_new;
    logic [FB_W-1:0] fb_new;

    always_comb begin
        d           = q;
        d.done      = 1'b0;
        d.div_start = 1'b0;
        launch      = 1'b0;
        advance     = 1'b0;
        la          = '0;
        lb          = '0;
        p_next      = q.p + 1'b1;
        hi_new      = (div_q > PW'(P_CAP)) ? P_CAP : div_q[FW-1:0];
        fb_new      = div_q[FB_W-1:0];

        unique case (q.state)
            S_IDLE: begin
                if (start) begin
                    d.fin   = fin_hz;
                    d.tgt   = {req_hz, 1'b0};
                    launch  = 1'b1;
                    la      = PW'(fin_hz) + PW'(PFD_MAX_HZ - 1);
                    lb      = PW'(PFD_MAX_HZ);
                    d.state = S_LO;
                end
            end
            S_LO: begin
                if (div_done) begin
                    d.p_lo  = div_q[FW-1:0];
                    launch  = 1'b1;
                    la      = PW'(q.fin);
                    lb      = PW'(PFD_MIN_HZ);
                    d.state = S_HI;
                end
            end
            S_HI: begin
                if (div_done) begin
                    d.p_hi      = hi_new;
                    d.p         = q.p_lo;
                    d.best_err  = '1;
                    d.best_freq = '0;
                    d.found     = 1'b0;
                    if ((q.fin == '0) || (q.p_lo > hi_new)) begin
                        d.state = S_FINISH;
                    end else begin
                        launch  = 1'b1;
                        la      = PW'(q.tgt) * PW'(q.p_lo);
                        lb      = PW'(q.fin);
                        d.state = S_FB;
                    end
                end
            end
            S_FB: begin
                if (div_done) begin
                    if (fb_ok) begin
                        d.fb    = fb_new;
                        launch  = 1'b1;
                        la      = PW'(fb_new) * PW'(q.fin);
                        lb      = PW'(q.p);
                        d.state = S_FQ;
                    end else begin
                        advance = 1'b1;
                    end
                end
            end
            S_FQ: begin
                if (div_done) begin
                    if (better) begin
                        d.best_p    = q.p[PRE_W-1:0];
                        d.best_fb   = q.fb;
                        d.best_err  = cand_err;
                        d.best_freq = div_q[TW-1:0];
                        d.found     = 1'b1;
                    end
                    advance = 1'b1;
                end
            end
            S_FINISH: begin
                d.done  = 1'b1;
                d.valid = q.found;
                if (q.found) begin
                    d.prediv = q.best_p;
                    d.fbdiv  = q.best_fb;
                    d.rate   = q.best_freq[TW-1:1];
                end else begin
                    d.rate   = '0;
                end
                d.state = S_IDLE;
            end
            default: d.state = S_IDLE;
        endcase

        if (advance) begin
            if (q.p == q.p_hi) begin
                d.state = S_FINISH;
            end else begin
                d.p     = p_next;
                launch  = 1'b1;
                la      = PW'(q.tgt) * PW'(p_next);
                lb      = PW'(q.fin);
                d.state = S_FB;
            end
        end

        if (launch) begin
            d.div_start = 1'b1;
            d.div_a     = la;
            d.div_b     = lb;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign prediv  = q.prediv;
    assign fbdiv   = q.fbdiv;
    assign rate_hz = q.rate;
    assign valid   = q.valid;
    assign done    = q.done;

    // R7: done lasts exactly one cycle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);
    // R7: results hold steady outside the done cycle
    a_r7_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !q.done |-> ($stable(q.rate) && $stable(q.prediv) && $stable(q.fbdiv) && $stable(q.valid)));
    // R1: a reported rate never exceeds half the target
    a_r1_rate_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && q.valid) |-> ({q.rate, 1'b0} <= q.tgt));
    // R3: an accepted feedback divider is never an excluded value
    a_r3_fb_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && q.valid) |-> (q.fbdiv >= FB_W'(FB_MIN) && q.fbdiv != FB_W'(FB_BAN)));
    // R2: an accepted pre-divider is never zero
    a_r2_prediv_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && q.valid) |-> (q.prediv != '0));
    // R4: the best error only shrinks while candidates are evaluated
    a_r4_err_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_FQ) |=> (q.best_err <= $past(q.best_err)));
    // R8: a running search keeps its captured target
    a_r8_target_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state != S_IDLE) |=> $stable(q.tgt));

endmodule

// File: tb/pll_div_search_test.sv
module pll_div_search_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] fin_hz = '0;
    logic [31:0] req_hz = '0;
    logic [4:0]  prediv;
    logic [8:0]  fbdiv;
    logic [7:0]  ctrl0, ctrl1;
    logic [31:0] rate_hz;
    logic        valid, done;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    pll_div_search uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .fin_hz(fin_hz), .req_hz(req_hz),
        .prediv(prediv), .fbdiv(fbdiv), .ctrl0(ctrl0), .ctrl1(ctrl1),
        .rate_hz(rate_hz), .valid(valid), .done(done)
    );

    typedef struct packed {
        logic [31:0] fin;
        logic [31:0] req;
        logic        v;
        logic [4:0]  p;
        logic [8:0]  fb;
        logic [31:0] rate;
        logic [7:0]  c0;
        logic [7:0]  c1;
    } vec_t;

    // fin, req, valid, prediv, fbdiv, rate, ctrl0, ctrl1
    localparam vec_t VECS [7] = '{
        '{32'd24_000_000, 32'd500_000_000,   1'b1, 5'd3, 9'd125, 32'd500_000_000,   8'h03, 8'h7D}, // R4 exact hit at p=3
        '{32'd24_000_000, 32'd100_000_000,   1'b1, 5'd3, 9'd25,  32'd100_000_000,   8'h03, 8'h19}, // R3 p=1 below 12
        '{32'd24_000_000, 32'd180_000_000,   1'b1, 5'd2, 9'd30,  32'd180_000_000,   8'h02, 8'h1E}, // R3 p=1 gives 15
        '{32'd24_000_000, 32'd3_100_000_000, 1'b1, 5'd1, 9'd258, 32'd3_096_000_000, 8'h21, 8'h02}, // R6 bit 8, R3 >511
        '{32'd24_000_000, 32'd600_000_000,   1'b1, 5'd1, 9'd50,  32'd600_000_000,   8'h01, 8'h32}, // R4 tie to smallest p
        '{32'd100_000_000, 32'd500_000_000,  1'b1, 5'd3, 9'd30,  32'd500_000_000,   8'h03, 8'h1E}, // R2 lower bound 3
        '{32'd24_000_000, 32'd30_000_000,    1'b0, 5'd3, 9'd30,  32'd0,             8'h03, 8'h1E}  // R2 upper bound, R5
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(done, {tag, " done seen"}, 64'(done), 64'd1);
    endtask

    task automatic run(input logic [31:0] f, input logic [31:0] r, input string tag);
        @(negedge clk);
        fin_hz = f;
        req_hz = r;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        wait_done(tag);
    endtask

    task automatic expect_all(input vec_t e, input string tag);
        chk(valid == e.v,      {tag, " valid"},  64'(valid),   64'(e.v));
        chk(prediv == e.p,     {tag, " prediv"}, 64'(prediv),  64'(e.p));
        chk(fbdiv == e.fb,     {tag, " fbdiv"},  64'(fbdiv),   64'(e.fb));
        chk(rate_hz == e.rate, {tag, " rate"},   64'(rate_hz), 64'(e.rate));
        chk(ctrl0 == e.c0,     {tag, " R6 ctrl0"}, 64'(ctrl0), 64'(e.c0));
        chk(ctrl1 == e.c1,     {tag, " R6 ctrl1"}, 64'(ctrl1), 64'(e.c1));
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        vec_t e;
        logic [31:0] held_rate;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        chk(prediv == 0 && fbdiv == 0, "R9 dividers", 64'({prediv, fbdiv}), 64'd0);
        chk(ctrl0 == 0 && ctrl1 == 0,  "R9 ctrl",     64'({ctrl0, ctrl1}), 64'd0);
        chk(rate_hz == 0 && !valid && !done, "R9 rate/valid/done", 64'({rate_hz, valid, done}), 64'd0);

        // Table walk: R1 R2 R3 R4 R5 R6
        for (int i = 0; i < 7; i++) begin
            run(VECS[i].fin, VECS[i].req, $sformatf("R1-vec%0d", i));
            expect_all(VECS[i], $sformatf("vec%0d", i));
        end

        // R7: one-cycle done, outputs held afterwards
        run(32'd24_000_000, 32'd500_000_000, "R7 run");
        held_rate = rate_hz;
        @(negedge clk);
        chk(!done, "R7 done width", 64'(done), 64'd0);
        repeat (5) @(negedge clk);
        chk(rate_hz == held_rate, "R7 rate held", 64'(rate_hz), 64'(held_rate));

        // R5 / R2: reference below 5 MHz gives empty range, dividers kept
        run(32'd4_000_000, 32'd100_000_000, "R5 run");
        e = '{32'd0, 32'd0, 1'b0, 5'd3, 9'd125, 32'd0, 8'h03, 8'h7D};
        expect_all(e, "R5 empty range");

        // R10: zero reference
        run(32'd0, 32'd100_000_000, "R10 run");
        expect_all(e, "R10 zero ref");

        // R8: start during a search is ignored
        @(negedge clk);
        fin_hz = 32'd24_000_000;
        req_hz = 32'd600_000_000;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        repeat (10) @(negedge clk);
        fin_hz = 32'd24_000_000;
        req_hz = 32'd500_000_000;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        wait_done("R8 run");
        e = '{32'd0, 32'd0, 1'b1, 5'd1, 9'd50, 32'd600_000_000, 8'h01, 8'h32};
        expect_all(e, "R8 ignored start");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule